// File: doc/BRIEF.md
# Move-Wide Immediate Execution Unit

This unit executes the move-wide-immediate instruction class of a 64-bit processor. Each cycle it can accept a 32-bit instruction word with a valid strobe, together with the current contents of the destination register. One cycle later it presents a registered write-back bundle: the destination index, a 64-bit result, a write enable and an undefined-instruction flag.

A 16-bit immediate is placed at one of four halfword positions. The unit supports three operations. The zeroing move clears every other bit. The inverted move complements the whole placed value. The keep move splices the immediate into the old register value and leaves the other bits unchanged. In the 32-bit operand size the upper word of the result is always cleared, and halfword positions above the lower word are illegal. Words that do not belong to this instruction class are dropped without any response, so the unit can sit beside other execution units that see the same instruction stream.

Top module: `mwi_unit`

## Requirements
- R1: Opcode (bits 30:29) `10` is the zeroing move: the result is imm16 (bits 20:5) shifted left by 16 times hw (bits 22:21), with every other bit zero.
- R2: Opcode `00` is the inverted move: the result is the bitwise complement of the shifted imm16.
- R3: Opcode `11` is the keep move: result bits [16*hw+15 : 16*hw] become imm16, and every other bit equals the old destination value `in_old`.
- R4: When the size bit (bit 31) is 0, result bits 63:32 are zero for all three operations, including the inverted move (the clearing is applied after the complement).
- R5: Opcode `01` sets `out_undef` and keeps `out_wen` low.
- R6: With size bit 0, an hw of 2 or 3 sets `out_undef` and keeps `out_wen` low.
- R7: A word whose bits 28:23 differ from `100101` is ignored: `out_valid`, `out_wen` and `out_undef` all stay low in the following cycle.
- R8: Outputs appear exactly one cycle after the input is accepted. `out_wen` and `out_undef` are never high together, and all three flags are low in the cycle after `in_valid` is low.
- R9: Destination index 31 (bits 4:0) still produces `out_valid` and a correct result, but `out_wen` stays low.
- R10: A synchronous active-high reset clears `out_valid`, `out_wen` and `out_undef` in the cycle after it is sampled, even if an instruction is presented at that time.
- R11: `out_rd` carries bits 4:0 of the accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word is present |
| in_insn | input | 32 | Instruction word |
| in_old | input | 64 | Current value of the destination register |
| out_valid | output | 1 | Accepted instruction of this class (registered) |
| out_rd | output | 5 | Destination register index |
| out_data | output | 64 | Write-back value |
| out_wen | output | 1 | Register write enable |
| out_undef | output | 1 | Undefined-instruction flag |

## Verification
On every cycle, the assertions check that write and undefined are mutually exclusive, that the flags stay low after idle or reset cycles, that an index of 31 is never written, that the reserved opcode and out-of-range halfword positions in 32-bit mode are flagged, that foreign words are dropped, and that 32-bit results have a zero upper word. Only the bench's scenarios show the arithmetic content of the result. These scenarios cover the placement at each halfword, the complement and its ordering against the zero-extension, the splice into the old value, the passing of the index, and a reset that arrives together with a live instruction. The bench compares each output against a shift-and-mask model that is independent of the per-lane structure of the design.

// File: rtl/mwi_pkg.sv
package mwi_pkg;

    localparam int XLEN   = 64;
    localparam int HALF   = 16;
    localparam int REGW   = 5;
    localparam int IW     = 32;
    localparam int LANES  = XLEN / HALF;
    localparam int HWW    = $clog2(LANES);
    localparam int FIXW   = 6;
    localparam logic [FIXW-1:0] CLASS_TAG = 6'b100101;

    typedef enum logic [1:0] {
        OP_INV  = 2'b00,
        OP_RSV  = 2'b01,
        OP_ZERO = 2'b10,
        OP_KEEP = 2'b11
    } mw_op_e;

    typedef struct packed {
        logic            sf;
        mw_op_e          op;
        logic [HWW-1:0]  hw;
        logic [HALF-1:0] imm;
        logic [REGW-1:0] rd;
    } mw_fields_t;

    typedef struct packed {
        logic            valid;
        logic            wen;
        logic            undef;
        logic [REGW-1:0] rd;
        logic [XLEN-1:0] data;
    } mw_wb_t;

endpackage

// File: rtl/mwi_decode.sv
module mwi_decode
    import mwi_pkg::*;
#(
    parameter int P_IW   = IW,
    parameter int P_HALF = HALF,
    parameter int P_REGW = REGW,
    parameter int P_HWW  = HWW
) (
    input  logic [P_IW-1:0] insn,
    output mw_fields_t      fld,
    output logic            is_class,
    output logic            illegal,
    output logic            to_zero_reg
);
    localparam int IMM_LO = P_REGW;
    localparam int HW_LO  = IMM_LO + P_HALF;
    localparam int FIX_LO = HW_LO + P_HWW;
    localparam int OPC_LO = FIX_LO + FIXW;
    localparam int SF_BIT = P_IW - 1;
    localparam int LANE_HALF = (1 << P_HWW) / 2;

    logic [FIXW-1:0] tag_d;
    logic            size_bad_d;

    always_comb begin
        fld.rd  = insn[IMM_LO-1:0];
        fld.imm = insn[HW_LO-1:IMM_LO];
        fld.hw  = insn[FIX_LO-1:HW_LO];
        tag_d   = insn[OPC_LO-1:FIX_LO];
        fld.op  = mw_op_e'(insn[SF_BIT-1:OPC_LO]);
        fld.sf  = insn[SF_BIT];

        is_class    = (tag_d == CLASS_TAG);
        size_bad_d  = !fld.sf && (int'(fld.hw) >= LANE_HALF);
        illegal     = (fld.op == OP_RSV) || size_bad_d;
        to_zero_reg = (fld.rd == {P_REGW{1'b1}});
    end

endmodule

// File: rtl/mwi_merge.sv
module mwi_merge
    import mwi_pkg::*;
#(
    parameter int P_XLEN = XLEN,
    parameter int P_HALF = HALF
) (
    input  mw_fields_t        fld,
    input  logic [P_XLEN-1:0] old_val,
    output logic [P_XLEN-1:0] result
);
    localparam int NLANE = P_XLEN / P_HALF;
    localparam int LOWER = NLANE / 2;

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        logic            hit_d;
        logic [P_HALF-1:0] lane_d;

        always_comb begin
            hit_d = (int'(fld.hw) == k);
            unique case (fld.op)
                OP_ZERO: lane_d = hit_d ? fld.imm : '0;
                OP_INV:  lane_d = hit_d ? ~fld.imm : '1;
                OP_KEEP: lane_d = hit_d ? fld.imm : old_val[k*P_HALF +: P_HALF];
                default: lane_d = '0;
            endcase
            if (!fld.sf && (k >= LOWER)) begin
                lane_d = '0;
            end
        end

        assign result[k*P_HALF +: P_HALF] = lane_d;
    end

endmodule

// File: rtl/mwi_unit.sv
module mwi_unit
    import mwi_pkg::*;
#(
    parameter int P_XLEN = XLEN,
    parameter int P_IW   = IW,
    parameter int P_REGW = REGW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [P_IW-1:0]   in_insn,
    input  logic [P_XLEN-1:0] in_old,
    output logic              out_valid,
    output logic [P_REGW-1:0] out_rd,
    output logic [P_XLEN-1:0] out_data,
    output logic              out_wen,
    output logic              out_undef
);
    localparam int UPPER_LO = P_XLEN / 2;

    mw_fields_t        fld;
    logic              is_class;
    logic              illegal;
    logic              to_zero_reg;
    logic [P_XLEN-1:0] merged;
    logic              accept_d;

    mw_wb_t st_d, st_q;

    mwi_decode #(.P_IW(P_IW), .P_HALF(HALF), .P_REGW(P_REGW), .P_HWW(HWW)) u_dec (
        .insn        (in_insn),
        .fld         (fld),
        .is_class    (is_class),
        .illegal     (illegal),
        .to_zero_reg (to_zero_reg)
    );

    mwi_merge #(.P_XLEN(P_XLEN), .P_HALF(HALF)) u_merge (
        .fld     (fld),
        .old_val (in_old),
        .result  (merged)
    );

    always_comb begin
        st_d     = st_q;
        accept_d = in_valid && is_class;
        st_d.valid = accept_d;
        st_d.undef = accept_d && illegal;
        st_d.wen   = accept_d && !illegal && !to_zero_reg;
        if (accept_d) begin
            st_d.rd   = fld.rd;
            st_d.data = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_rd    = st_q.rd;
    assign out_data  = st_q.data;
    assign out_wen   = st_q.wen;
    assign out_undef = st_q.undef;

    // R8
    wen_undef_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_wen && out_undef));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_valid) && !$past(rst)) |-> (!out_valid && !out_wen && !out_undef));

    // R9
    zero_reg_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        out_wen |-> (out_rd != {P_REGW{1'b1}}));

    // R5
    rsv_opcode_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_class && fld.op == OP_RSV) |=> (out_undef && !out_wen));

    // R6
    narrow_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_class && !fld.sf && fld.hw[HWW-1]) |=> (out_undef && !out_wen));

    // R7
    foreign_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_class) |=> (!out_valid && !out_wen && !out_undef));

    // R4
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_class && !fld.sf) |=> (out_data[P_XLEN-1:UPPER_LO] == '0));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !out_wen && !out_undef));

endmodule

// File: tb/tb_mwi_unit.sv
`timescale 1ns/1ps
module tb_mwi_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_insn = '0;
    logic [63:0] in_old = '0;
    logic        out_valid;
    logic [4:0]  out_rd;
    logic [63:0] out_data;
    logic        out_wen;
    logic        out_undef;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          valid;
        bit          wen;
        bit          undef;
        bit          chkdata;
        logic [4:0]  rd;
        logic [63:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    mwi_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn), .in_old(in_old),
        .out_valid(out_valid), .out_rd(out_rd), .out_data(out_data),
        .out_wen(out_wen), .out_undef(out_undef)
    );

    function automatic logic [31:0] mk(bit sf, logic [1:0] opc, logic [1:0] hw,
                                       logic [15:0] imm, logic [4:0] rd);
        return {sf, opc, 6'b100101, hw, imm, rd};
    endfunction

    function automatic exp_t model(logic [31:0] w, logic [63:0] old, string tag);
        exp_t e;
        logic [63:0] mask, placed, r;
        int sh;
        bit cls, ill;
        sh     = 16 * int'(w[22:21]);
        mask   = 64'hFFFF << sh;
        placed = {48'h0, w[20:5]} << sh;
        case (w[30:29])
            2'b10:   r = placed;
            2'b00:   r = ~placed;
            2'b11:   r = (old & ~mask) | placed;
            default: r = '0;
        endcase
        if (!w[31]) r[63:32] = '0;
        cls = (w[28:23] == 6'b100101);
        ill = (w[30:29] == 2'b01) || (!w[31] && w[22]);
        e.valid   = cls;
        e.undef   = cls && ill;
        e.wen     = cls && !ill && (w[4:0] != 5'd31);
        e.chkdata = cls && !ill;
        e.rd      = w[4:0];
        e.data    = r;
        e.tag     = tag;
        return e;
    endfunction

    task automatic drive(logic [31:0] w, logic [63:0] old, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_insn  = w;
        in_old   = old;
        exp_q.push_back(model(w, old, tag));
    endtask

    task automatic idle(string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b0;
        in_insn  = $urandom;
        e = '{valid: 0, wen: 0, undef: 0, chkdata: 0, rd: '0, data: '0, tag: tag};
        exp_q.push_back(e);
    endtask

    task automatic fail_line(string tag, string what, logic [63:0] act, logic [63:0] exp);
        errors++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    // monitor: samples 5 ns after the rising edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                checks++;
                if (out_valid !== e.valid) fail_line(e.tag, "valid", 64'(out_valid), 64'(e.valid));
                else if (out_wen !== e.wen) fail_line(e.tag, "wen", 64'(out_wen), 64'(e.wen));
                else if (out_undef !== e.undef) fail_line(e.tag, "undef", 64'(out_undef), 64'(e.undef));
                else if (e.valid && out_rd !== e.rd) fail_line(e.tag, "rd", 64'(out_rd), 64'(e.rd));
                else if (e.chkdata && out_data !== e.data) fail_line(e.tag, "data", out_data, e.data);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        exp_t e;
        // R10 reset state
        repeat (2) @(posedge clk);
        #5;
        checks++;
        if (out_valid || out_wen || out_undef)
            fail_line("R10", "reset flags", {61'h0, out_valid, out_wen, out_undef}, 64'h0);
        @(negedge clk);
        rst = 1'b0;

        // R1 R11 zeroing move at each halfword, 64-bit
        drive(mk(1, 2'b10, 2'd0, 16'hBEEF, 5'd3), 64'hFFFF_FFFF_FFFF_FFFF, "R1_hw0");
        drive(mk(1, 2'b10, 2'd1, 16'h1234, 5'd7), 64'h0, "R1_hw1");
        drive(mk(1, 2'b10, 2'd2, 16'h8001, 5'd12), 64'h0, "R1_hw2");
        drive(mk(1, 2'b10, 2'd3, 16'hFFFF, 5'd30), 64'h0, "R11_hw3");
        // R2 inverted move
        drive(mk(1, 2'b00, 2'd2, 16'h00F0, 5'd1), 64'h0, "R2_hw2");
        drive(mk(1, 2'b00, 2'd0, 16'h0000, 5'd2), 64'h0, "R2_allones");
        // R3 keep move
        drive(mk(1, 2'b11, 2'd3, 16'hCAFE, 5'd4), 64'h0123_4567_89AB_CDEF, "R3_hw3");
        drive(mk(1, 2'b11, 2'd1, 16'h0000, 5'd5), 64'hFFFF_FFFF_FFFF_FFFF, "R3_hw1");
        // R4 narrow size
        drive(mk(0, 2'b00, 2'd1, 16'h1234, 5'd6), 64'h0, "R4_inv");
        drive(mk(0, 2'b11, 2'd0, 16'hA5A5, 5'd8), 64'hFFFF_FFFF_FFFF_FFFF, "R4_keep");
        drive(mk(0, 2'b10, 2'd1, 16'h7777, 5'd9), 64'h0, "R4_zero");
        // R5 reserved opcode
        drive(mk(1, 2'b01, 2'd0, 16'h1111, 5'd10), 64'h0, "R5");
        // R6 illegal shifts in narrow mode
        drive(mk(0, 2'b10, 2'd2, 16'h2222, 5'd11), 64'h0, "R6_hw2");
        drive(mk(0, 2'b11, 2'd3, 16'h3333, 5'd13), 64'h0, "R6_hw3");
        // R7 foreign word
        drive(32'hD503_201F, 64'h0, "R7_a");
        drive(mk(1, 2'b10, 2'd0, 16'h1, 5'd1) ^ 32'h0080_0000, 64'h0, "R7_b");
        // R8 idle gap
        idle("R8_idle");
        idle("R8_idle2");
        // R9 zero register
        drive(mk(1, 2'b00, 2'd1, 16'h5555, 5'd31), 64'h0, "R9");
        drive(mk(1, 2'b11, 2'd0, 16'h4444, 5'd31), 64'hABCD_0000_0000_0000, "R9_keep");
        // R10 reset while a valid instruction is presented
        @(negedge clk);
        in_valid = 1'b1;
        in_insn  = mk(1, 2'b10, 2'd0, 16'h9999, 5'd14);
        rst      = 1'b1;
        e = '{valid: 0, wen: 0, undef: 0, chkdata: 0, rd: '0, data: '0, tag: "R10_mid"};
        exp_q.push_back(e);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        exp_q.push_back('{valid: 0, wen: 0, undef: 0, chkdata: 0, rd: '0, data: '0, tag: "R10_after"});

        // R8 back-to-back mixed stream
        lf = 32'h1ACE_B00C;
        for (int i = 0; i < 60; i++) begin
            logic [31:0] w;
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            w = lf;
            if (lf[3:2] != 2'b00) w[28:23] = 6'b100101;
            drive(w, {lf, ~lf}, "R8_stream");
        end
        idle("R8_tail");
        idle("R8_tail2");
        while (exp_q.size() > 0) @(posedge clk);
        #6;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule